// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block collects the interrupt sources of a CAN controller into a small set of sticky flags and raises one interrupt request toward the CPU. Single-cycle event pulses arrive from the protocol core and from the mailbox logic. Receive-complete, transmit-complete and transmit-cancelled events come as one bit per mailbox. The other sources are bus activity, error warning and the end of a wake from standby. A per-mailbox mask stops masked mailboxes from ever setting the completion flags. A second mask register keeps flagged sources off the interrupt line. The only source it cannot mask is the reset flag. That flag is set out of reset and again each time the controller leaves standby.

Software reaches four 16-bit registers over a simple register bus. The bus takes byte and word accesses. Software clears a flag by writing one to its bit. A longword access, a word access at an odd address, and any access while the medium-speed input is high are all refused: the write is dropped and the read returns zero. A status word shows the sleep state. Its reset-status bit reads as one while the controller sleeps.

Register map, by byte address: 0x0 flags, 0x2 event mask, 0x4 mailbox mask, 0x6 status (read only). Flag and event-mask bit positions: 0 reset, 1 receive complete, 2 transmit complete, 3 transmit cancelled, 4 bus activity, 5 error warning. Bit 0 of the event mask always reads zero. Status bit 0 is the reset status and bit 1 is the sleep state.

Top module: `can_irq_flags`

## Requirements
- R1: After reset the flag word reads 0x0001, the event mask reads 0x003E, the mailbox mask reads all ones, and irq_o is high.
- R2: While flag bit 0 (reset) is set, irq_o is high whatever the event mask holds.
- R3: A pulse on wake_done_i sets flag bit 0 on the next clock.
- R4: A receive, transmit or cancel pulse from a mailbox whose mailbox-mask bit is 1 leaves flag bits 1, 2 and 3 unchanged.
- R5: A receive, transmit or cancel pulse from a mailbox whose mask bit is 0 sets flag bit 1, 2 or 3 respectively on the next clock.
- R6: bus_act_i sets flag bit 4 only while sleep_i is high. It has no effect while sleep_i is low.
- R7: Status bit 0 reads 1 while sleep_i is high or flag bit 0 is set. Status bit 1 follows sleep_i.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: When an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: irq_o is flag bit 0 ORed with every flag bit 1 to 5 whose event-mask bit is 0.
- R11: bus_size_i 0 is a byte access. Address bit 0 picks the lane: 0 selects data bits 7:0 and 1 selects bits 15:8. A byte read returns zero in the other lane. bus_size_i 1 is a word access.
- R12: bus_size_i 2 or 3 (longword) and a word access at an odd address are refused: the write has no effect and the read returns zero.
- R13: While medium_speed_i is high, register writes have no effect and reads return zero.
- R14: An err_warn_i pulse sets flag bit 5 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_done_i | input | 1 | Pulse when recovery from standby completes |
| sleep_i | input | 1 | Controller is in sleep mode |
| medium_speed_i | input | 1 | Medium-speed mode, register access blocked |
| rx_done_i | input | NUM_MB | Per-mailbox receive-complete pulses |
| tx_done_i | input | NUM_MB | Per-mailbox transmit-complete pulses |
| tx_cancel_i | input | NUM_MB | Per-mailbox transmit-cancelled pulses |
| bus_act_i | input | 1 | Bus activity pulse |
| err_warn_i | input | 1 | Error warning pulse |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_size_i | input | 2 | 0 byte, 1 word, 2/3 longword |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 16 | Write data, lane aligned |
| bus_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the reset flag holds the request high, that no request appears without a flag, and that wake, sleep-gated bus activity and unmasked completions set their flags. They also check that masked mailboxes cannot set a clear flag and that refused reads return zero. Byte-lane placement, write-one-to-clear, the event-over-clear priority, mask writes and the status word can only be shown by the bench's access sequences. The bench's reference model follows the interrupt line on every clock throughout those sequences.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_REGS  = 4;

  localparam int FL_RST  = 0;
  localparam int FL_RX   = 1;
  localparam int FL_TX   = 2;
  localparam int FL_CAN  = 3;
  localparam int FL_BUS  = 4;
  localparam int FL_WARN = 5;

  localparam int REG_FLAG = 0;
  localparam int REG_EMSK = 1;
  localparam int REG_MBMK = 2;
  localparam int REG_STAT = 3;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST_VAL = 6'b000001;
  localparam logic [NUM_FLAGS-1:0] EMSK_RST_VAL = 6'b111110;
  localparam logic [NUM_FLAGS-1:0] EMSK_WR_BITS = 6'b111110;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/can_irq_access.sv
module can_irq_access
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [1:0]          size_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                slow_i,
  output logic                wr_ok_o,
  output logic                rd_ok_o,
  output logic [NUM_REGS-1:0] reg_hit_o,
  output logic [REG_W-1:0]    lane_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic size_ok;
  logic acc_ok;

  always_comb begin
    size_ok = 1'b0;
    lane_o  = '0;
    case (acc_size_e'(size_i))
      SZ_BYTE: begin
        size_ok = 1'b1;
        lane_o  = addr_i[0] ? 16'hFF00 : 16'h00FF;
      end
      SZ_WORD: begin
        size_ok = ~addr_i[0];
        lane_o  = 16'hFFFF;
      end
      default: begin
        size_ok = 1'b0;
        lane_o  = '0;
      end
    endcase
    acc_ok  = sel_i & ~slow_i & size_ok;
    wr_ok_o = acc_ok & wr_i;
    rd_ok_o = acc_ok & ~wr_i;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign reg_hit_o[r] = (addr_i[ADDR_W-1:1] == IDX_W'(r));
  end
endmodule

// File: rtl/can_irq_evgate.sv
module can_irq_evgate #(
  parameter int NUM_MB = 16
) (
  input  logic [NUM_MB-1:0] mbmask_i,
  input  logic [NUM_MB-1:0] rx_i,
  input  logic [NUM_MB-1:0] tx_i,
  input  logic [NUM_MB-1:0] cancel_i,
  output logic              rx_hit_o,
  output logic              tx_hit_o,
  output logic              cancel_hit_o
);
  logic [NUM_MB-1:0] rx_open;
  logic [NUM_MB-1:0] tx_open;
  logic [NUM_MB-1:0] cn_open;

  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    assign rx_open[m] = rx_i[m]     & ~mbmask_i[m];
    assign tx_open[m] = tx_i[m]     & ~mbmask_i[m];
    assign cn_open[m] = cancel_i[m] & ~mbmask_i[m];
  end

  assign rx_hit_o     = |rx_open;
  assign tx_hit_o     = |tx_open;
  assign cancel_hit_o = |cn_open;
endmodule

// File: rtl/can_irq_flagbank.sv
module can_irq_flagbank
  import can_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_d;
  logic [NUM_FLAGS-1:0] flag_en;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_comb begin
      flag_en[f] = set_i[f] | clr_i[f];
      flag_d[f]  = set_i[f] | (flag_q[f] & ~clr_i[f]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[f] <= FLAG_RST_VAL[f];
      end else if (flag_en[f]) begin
        flag_q[f] <= flag_d[f];
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_irq_maskregs.sv
module can_irq_maskregs
  import can_irq_pkg::*;
#(
  parameter int NUM_MB = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 emsk_we_i,
  input  logic                 mbmk_we_i,
  input  logic [REG_W-1:0]     lane_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [NUM_FLAGS-1:0] emask_o,
  output logic [NUM_MB-1:0]    mbmask_o
);
  logic [NUM_FLAGS-1:0] emask_q;
  logic [NUM_FLAGS-1:0] emask_d;
  logic [NUM_FLAGS-1:0] emask_bits;
  logic [NUM_MB-1:0]    mbmask_q;
  logic [NUM_MB-1:0]    mbmask_d;
  logic [NUM_MB-1:0]    mb_bits;

  always_comb begin
    emask_bits = lane_i[NUM_FLAGS-1:0] & EMSK_WR_BITS;
    emask_d    = (emask_q & ~emask_bits) | (wdata_i[NUM_FLAGS-1:0] & emask_bits);
    mb_bits    = lane_i[NUM_MB-1:0];
    mbmask_d   = (mbmask_q & ~mb_bits) | (wdata_i[NUM_MB-1:0] & mb_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emask_q <= EMSK_RST_VAL;
    end else if (emsk_we_i) begin
      emask_q <= emask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbmask_q <= '1;
    end else if (mbmk_we_i) begin
      mbmask_q <= mbmask_d;
    end
  end

  assign emask_o  = emask_q;
  assign mbmask_o = mbmask_q;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_done_i,
  input  logic              sleep_i,
  input  logic              medium_speed_i,
  input  logic [NUM_MB-1:0] rx_done_i,
  input  logic [NUM_MB-1:0] tx_done_i,
  input  logic [NUM_MB-1:0] tx_cancel_i,
  input  logic              bus_act_i,
  input  logic              err_warn_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  output logic              irq_o
);
  logic                 wr_ok;
  logic                 rd_ok;
  logic [NUM_REGS-1:0]  reg_hit;
  logic [REG_W-1:0]     lane;
  logic                 rx_hit;
  logic                 tx_hit;
  logic                 cn_hit;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] emask_q;
  logic [NUM_MB-1:0]    mbmask_q;
  logic [REG_W-1:0]     word_mux [NUM_REGS];
  logic [REG_W-1:0]     rd_word;

  can_irq_access #(.ADDR_W(ADDR_W)) u_access (
    .sel_i     (bus_sel_i),
    .wr_i      (bus_wr_i),
    .size_i    (bus_size_i),
    .addr_i    (bus_addr_i),
    .slow_i    (medium_speed_i),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok),
    .reg_hit_o (reg_hit),
    .lane_o    (lane)
  );

  can_irq_evgate #(.NUM_MB(NUM_MB)) u_evgate (
    .mbmask_i     (mbmask_q),
    .rx_i         (rx_done_i),
    .tx_i         (tx_done_i),
    .cancel_i     (tx_cancel_i),
    .rx_hit_o     (rx_hit),
    .tx_hit_o     (tx_hit),
    .cancel_hit_o (cn_hit)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FL_RST]  = wake_done_i;
    flag_set[FL_RX]   = rx_hit;
    flag_set[FL_TX]   = tx_hit;
    flag_set[FL_CAN]  = cn_hit;
    flag_set[FL_BUS]  = bus_act_i & sleep_i;
    flag_set[FL_WARN] = err_warn_i;
    flag_clr = (wr_ok && reg_hit[REG_FLAG]) ?
               (bus_wdata_i[NUM_FLAGS-1:0] & lane[NUM_FLAGS-1:0]) : '0;
  end

  can_irq_flagbank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  can_irq_maskregs #(.NUM_MB(NUM_MB)) u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .emsk_we_i (wr_ok & reg_hit[REG_EMSK]),
    .mbmk_we_i (wr_ok & reg_hit[REG_MBMK]),
    .lane_i    (lane),
    .wdata_i   (bus_wdata_i),
    .emask_o   (emask_q),
    .mbmask_o  (mbmask_q)
  );

  always_comb begin
    word_mux[REG_FLAG] = REG_W'(flag_q);
    word_mux[REG_EMSK] = REG_W'(emask_q);
    word_mux[REG_MBMK] = REG_W'(mbmask_q);
    word_mux[REG_STAT] = {14'd0, sleep_i, sleep_i | flag_q[FL_RST]};
    rd_word = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (reg_hit[r]) rd_word = rd_word | word_mux[r];
    end
    bus_rdata_o = rd_ok ? (rd_word & lane) : '0;
  end

  assign irq_o = flag_q[FL_RST] |
                 (|(flag_q[NUM_FLAGS-1:1] & ~emask_q[NUM_FLAGS-1:1]));
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wake_done_i,
  input logic                 sleep_i,
  input logic                 medium_speed_i,
  input logic [NUM_MB-1:0]    rx_done_i,
  input logic                 bus_act_i,
  input logic                 bus_sel_i,
  input logic                 bus_wr_i,
  input logic [1:0]           bus_size_i,
  input logic [15:0]          bus_rdata_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flag_q,
  input logic [NUM_MB-1:0]    mbmask_q
);
  // R2
  rst_flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[FL_RST] |-> irq_o);

  // R10
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq_o);

  // R3
  wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done_i |=> flag_q[FL_RST]);

  // R5
  rx_open_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_done_i & ~mbmask_q) != '0) |=> flag_q[FL_RX]);

  // R4
  rx_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[FL_RX] && ((rx_done_i & ~mbmask_q) == '0)) |=> !flag_q[FL_RX]);

  // R6
  bus_awake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !flag_q[FL_BUS]) |=> !flag_q[FL_BUS]);

  // R6
  bus_sleep_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && bus_act_i) |=> flag_q[FL_BUS]);

  // R12
  long_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && bus_size_i[1]) |-> (bus_rdata_o == 16'h0));

  // R13
  slow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && medium_speed_i) |-> (bus_rdata_o == 16'h0));
endmodule

bind can_irq_flags can_irq_flags_chk #(.NUM_MB(NUM_MB), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wake_done_i    (wake_done_i),
  .sleep_i        (sleep_i),
  .medium_speed_i (medium_speed_i),
  .rx_done_i      (rx_done_i),
  .bus_act_i      (bus_act_i),
  .bus_sel_i      (bus_sel_i),
  .bus_wr_i       (bus_wr_i),
  .bus_size_i     (bus_size_i),
  .bus_rdata_o    (bus_rdata_o),
  .irq_o          (irq_o),
  .flag_q         (flag_q),
  .mbmask_q       (mbmask_q)
);

// File: tb/test_can_irq_flags.sv
module test_can_irq_flags;
  localparam int NMB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake = 1'b0, sleep = 1'b0, med = 1'b0;
  logic [15:0] rx = '0, tx = '0, cn = '0;
  logic        bact = 1'b0, warn = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_irq_flags #(.NUM_MB(NMB), .ADDR_W(4)) i_can_irq_flags (
    .clk(clk), .rst_n(rst_n), .wake_done_i(wake), .sleep_i(sleep),
    .medium_speed_i(med), .rx_done_i(rx), .tx_done_i(tx), .tx_cancel_i(cn),
    .bus_act_i(bact), .err_warn_i(warn), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_size_i(size), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [15:0] m_flag, m_emsk, m_mb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 16'h0001; m_emsk <= 16'h003E; m_mb <= 16'hFFFF;
    end else begin
      bit ok;
      logic [15:0] ln, st, cl;
      int wi;
      ok = sel && !med && (size == 2'd0 || (size == 2'd1 && !addr[0]));
      ln = (size == 2'd1) ? 16'hFFFF : (addr[0] ? 16'hFF00 : 16'h00FF);
      wi = int'(addr) / 2;
      st = '0;
      if (wake) st[0] = 1'b1;
      if ((rx & ~m_mb) != 0) st[1] = 1'b1;
      if ((tx & ~m_mb) != 0) st[2] = 1'b1;
      if ((cn & ~m_mb) != 0) st[3] = 1'b1;
      if (bact && sleep) st[4] = 1'b1;
      if (warn) st[5] = 1'b1;
      cl = (ok && wr && wi == 0) ? (wdata & ln & 16'h003F) : 16'h0;
      m_flag <= (m_flag & ~cl) | st;
      if (ok && wr && wi == 1) m_emsk <= (m_emsk & ~(ln & 16'h003E)) | (wdata & ln & 16'h003E);
      if (ok && wr && wi == 2) m_mb <= (m_mb & ~ln) | (wdata & ln);
    end
  end

  // R10 interrupt line compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_irq;
      exp_irq = m_flag[0] || ((m_flag & ~m_emsk & 16'h003E) != 0);
      n_cmp++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL R10 irq_o act=%0b exp=%0b t=%0t", irq, exp_irq, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [3:0] a, input logic [1:0] sz,
                     input logic [15:0] d, input logic [15:0] r, input logic [15:0] t,
                     input logic [15:0] c, input bit b, input bit e, input bit wk);
    @(negedge clk);
    sel = w; wr = w; addr = a; size = sz; wdata = d;
    rx = r; tx = t; cn = c; bact = b; warn = e; wake = wk;
    @(negedge clk);
    sel = 0; wr = 0; rx = '0; tx = '0; cn = '0; bact = 0; warn = 0; wake = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [1:0] sz, input logic [15:0] d);
    cyc(1'b1, a, sz, d, '0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ev(input logic [15:0] r, input logic [15:0] t, input logic [15:0] c,
                    input bit b, input bit e, input bit wk);
    cyc(1'b0, 4'd0, 2'd1, 16'h0, r, t, c, b, e, wk);
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] sz,
                    input logic [15:0] exp);
    @(negedge clk);
    sel = 1; wr = 0; addr = a; size = sz;
    #1;
    chk(tag, rdata, exp);
    sel = 0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 flags", 4'h0, 2'd1, 16'h0001);
    rd("R1 emask", 4'h2, 2'd1, 16'h003E);
    rd("R1 mbmask", 4'h4, 2'd1, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'h1);
    // R2 reset flag unmaskable, R7 status from reset flag
    wr_reg(4'h2, 2'd1, 16'hFFFF);
    chk("R2 irq with all masked", {15'd0, irq}, 16'h1);
    rd("R7 status reset flag", 4'h6, 2'd1, 16'h0001);
    // R8 write zero keeps, write one clears
    wr_reg(4'h0, 2'd1, 16'h0000);
    rd("R8 zero write", 4'h0, 2'd1, 16'h0001);
    wr_reg(4'h0, 2'd1, 16'h0001);
    rd("R8 one write", 4'h0, 2'd1, 16'h0000);
    chk("R10 irq low", {15'd0, irq}, 16'h0);
    // R3 wake
    ev('0, '0, '0, 0, 0, 1);
    rd("R3 wake flag", 4'h0, 2'd1, 16'h0001);
    wr_reg(4'h0, 2'd1, 16'h0001);
    // R4 masked mailboxes
    ev(16'h0008, 16'h0020, 16'h0001, 0, 0, 0);
    rd("R4 masked events", 4'h0, 2'd1, 16'h0000);
    // R5 unmask mailbox 3
    wr_reg(4'h4, 2'd1, 16'hFFF7);
    ev(16'h0018, '0, '0, 0, 0, 0);
    ev('0, 16'h0008, 16'h0010, 0, 0, 0);
    rd("R5 rx/tx flags", 4'h0, 2'd1, 16'h0006);
    chk("R10 masked flags no irq", {15'd0, irq}, 16'h0);
    ev('0, '0, 16'h0008, 0, 0, 0);
    rd("R5 cancel flag", 4'h0, 2'd1, 16'h000E);
    wr_reg(4'h2, 2'd1, 16'h003C);
    chk("R10 unmasked rx irq", {15'd0, irq}, 16'h1);
    // R9 event beats clear
    cyc(1'b1, 4'h0, 2'd1, 16'h0002, 16'h0008, '0, '0, 0, 0, 0);
    rd("R9 event wins", 4'h0, 2'd1, 16'h000E);
    wr_reg(4'h0, 2'd1, 16'h000E);
    rd("R8 cleared", 4'h0, 2'd1, 16'h0000);
    // R6 bus activity gated by sleep
    ev('0, '0, '0, 1, 0, 0);
    rd("R6 awake ignored", 4'h0, 2'd1, 16'h0000);
    @(negedge clk); sleep = 1;
    ev('0, '0, '0, 1, 0, 0);
    rd("R6 sleep sets", 4'h0, 2'd1, 16'h0010);
    rd("R7 status sleep", 4'h6, 2'd1, 16'h0003);
    @(negedge clk); sleep = 0;
    rd("R7 status awake", 4'h6, 2'd1, 16'h0000);
    wr_reg(4'h0, 2'd1, 16'h0010);
    // R14 error warning
    ev('0, '0, '0, 0, 1, 0);
    rd("R14 warn flag", 4'h0, 2'd1, 16'h0020);
    wr_reg(4'h0, 2'd0, 16'h0020);
    rd("R11 byte clear", 4'h0, 2'd1, 16'h0000);
    // R11 byte lanes
    wr_reg(4'h5, 2'd0, 16'h00FF);
    rd("R11 hi lane write", 4'h4, 2'd1, 16'h00F7);
    rd("R11 hi byte read", 4'h5, 2'd0, 16'h0000);
    rd("R11 lo byte read", 4'h4, 2'd0, 16'h00F7);
    // R12 longword and misaligned word
    wr_reg(4'h4, 2'd2, 16'h0000);
    wr_reg(4'h5, 2'd1, 16'h0000);
    rd("R12 writes refused", 4'h4, 2'd1, 16'h00F7);
    rd("R12 long read", 4'h4, 2'd2, 16'h0000);
    // R13 medium speed
    @(negedge clk); med = 1;
    wr_reg(4'h2, 2'd1, 16'hFFFF);
    rd("R13 read blocked", 4'h2, 2'd1, 16'h0000);
    @(negedge clk); med = 0;
    rd("R13 write ignored", 4'h2, 2'd1, 16'h003C);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule